// File: doc/BRIEF.md
# Randomized Framed Packet Burst Generator

This block produces a burst of test frames as a byte stream toward a serial link. Each byte carries a control-character flag. Every frame opens with a start control symbol and carries a capture-time stamp taken from a free-running counter. Pseudo-random filler bytes follow, and an end control symbol closes the frame. A downstream checker can use the delimiters and the stamp to find damaged frames and to tell when they were sent. The number of filler bytes in each frame is drawn at random inside a programmable window.

Software or a controller loads the frame count and the length window, then pulses a start strobe. The generator emits the frames one after another, with a one-cycle idle slot between them. It raises a one-cycle done pulse once the last frame has been accepted. The byte stream uses a valid/ready handshake. A byte moves only in a cycle where valid and ready are both high. While ready is low, valid, the data byte and the control flag hold their values. The generator never withdraws a byte it has offered. Ready has no effect on the output in the same cycle, so the ready path holds no combinational logic.

Top module: `pkt_burst_gen`

## Requirements
- R1: After reset, `sym_valid_o`, `done_o` and `busy_o` are all 0.
- R2: A `start_i` pulse seen while idle latches `frame_cnt_i`, `pad_min_i` and `pad_max_i`, and the burst then holds exactly that many frames. A `start_i` pulse while busy is ignored. A count of 0 produces no frame, only the done pulse of R9.
- R3: Each frame is, in order: 0xFB with `sym_k_o`=1, then 4 stamp bytes, then the filler bytes, then 0xFD with `sym_k_o`=1. `sym_k_o` is 0 on every other valid byte.
- R4: The stamp is the value of `time_i` in the cycle the 0xFB byte is accepted, sent most significant byte first.
- R5: The filler count equals min + (r mod (max-min+1)). Here r is the 16-bit generator value when the 0xFB byte is accepted, and min and max are the latched window bounds. When max < min, the count is min. The generator steps once after this draw.
- R6: Each filler byte is the low byte of the 16-bit generator value, and the generator steps once after each accepted filler byte. The generator shifts left and takes in the XOR of bits 15, 13, 12 and 10. It starts from 0xACE1 after reset and is never reseeded between bursts.
- R7: While `sym_valid_o`=1 and `sym_ready_i`=0, the next cycle shows the same valid, data and flag.
- R8: After each non-final 0xFD is accepted, `sym_valid_o` is 0 for exactly one cycle, and the next frame's 0xFB follows.
- R9: `done_o` is high for exactly one cycle, in the cycle after the last 0xFD is accepted, or after a start with a count of 0. `busy_o` is high from the cycle after an accepted start until that same point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe for a burst |
| frame_cnt_i | input | 8 | Number of frames in the burst |
| pad_min_i | input | 8 | Lower bound on filler bytes |
| pad_max_i | input | 8 | Upper bound on filler bytes |
| time_i | input | 32 | Free-running time counter |
| sym_data_o | output | 8 | Output byte |
| sym_k_o | output | 1 | Byte is a control symbol |
| sym_valid_o | output | 1 | Output byte is valid |
| sym_ready_i | input | 1 | Sink accepts the byte |
| busy_o | output | 1 | Burst in progress |
| done_o | output | 1 | One-cycle pulse when the burst ends |

## Verification
The embedded properties watch every cycle for the following:
- the control flag never sits on anything but the two delimiters;
- a stalled byte stays frozen;
- each closing delimiter is followed by an idle slot;
- the done strobe never lasts two cycles;
- every drawn filler count falls inside the latched window.

Some behaviours can only be shown by the bench's scenarios, which compare against an independent stream model:
- that the stamp matches the counter at the moment the start symbol is taken;
- that the filler bytes follow the generator sequence across bursts;
- that an inverted window collapses to its minimum;
- that a mid-burst strobe is ignored;
- that a zero-count burst yields only the done pulse.

// File: rtl/pkt_burst_pkg.sv
package pkt_burst_pkg;
  localparam int RND_W = 16;
  localparam logic [7:0] SYM_OPEN  = 8'hFB;
  localparam logic [7:0] SYM_CLOSE = 8'hFD;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPEN,
    ST_STAMP,
    ST_FILL,
    ST_CLOSE,
    ST_GAP
  } gen_state_t;
endpackage

// File: rtl/rnd_shift16.sv
module rnd_shift16 #(
  parameter int          W    = 16,
  parameter logic [W-1:0] SEED = 16'hACE1,
  parameter logic [W-1:0] TAPS = 16'hB400
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_i,
  output logic [W-1:0] val_o
);
  logic [W-1:0] q;
  logic         fb;

  assign fb    = ^(q & TAPS);
  assign val_o = q;

  always_ff @(posedge clk) begin
    if (!rst_n)      q <= SEED;
    else if (step_i) q <= {q[W-2:0], fb};
  end

  // R6: a maximal-length sequence never reaches the all-zero lockup state
  p_rnd_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    q != '0);
endmodule

// File: rtl/pad_len_pick.sv
module pad_len_pick #(
  parameter int LEN_W = 8,
  parameter int RND_W = 16
) (
  input  logic [RND_W-1:0] rnd_i,
  input  logic [LEN_W-1:0] lo_i,
  input  logic [LEN_W-1:0] hi_i,
  output logic [LEN_W-1:0] len_o
);
  localparam int SPAN_W = LEN_W + 1;

  logic [SPAN_W-1:0] span;
  logic [RND_W-1:0]  span_ext;
  logic [LEN_W-1:0]  rem;

  assign span     = {1'b0, hi_i} - {1'b0, lo_i} + SPAN_W'(1);
  assign span_ext = RND_W'(span);
  assign rem      = LEN_W'(rnd_i % span_ext);
  assign len_o    = (hi_i < lo_i) ? lo_i : (lo_i + rem);
endmodule

// File: rtl/pkt_burst_gen.sv
module pkt_burst_gen
  import pkt_burst_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int LEN_W    = 8,
  parameter int TS_BYTES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [CNT_W-1:0]      frame_cnt_i,
  input  logic [LEN_W-1:0]      pad_min_i,
  input  logic [LEN_W-1:0]      pad_max_i,
  input  logic [8*TS_BYTES-1:0] time_i,
  output logic [7:0]            sym_data_o,
  output logic                  sym_k_o,
  output logic                  sym_valid_o,
  input  logic                  sym_ready_i,
  output logic                  busy_o,
  output logic                  done_o
);
  localparam int TS_W   = 8 * TS_BYTES;
  localparam int TIDX_W = (TS_BYTES > 1) ? $clog2(TS_BYTES) : 1;
  localparam logic [TIDX_W-1:0] TIDX_LAST = TIDX_W'(TS_BYTES - 1);

  gen_state_t       state;
  logic [CNT_W-1:0] frames_left;
  logic [LEN_W-1:0] lo_q, hi_q, fill_left, drawn_len;
  logic [TS_W-1:0]  stamp_q;
  logic [TIDX_W-1:0] stamp_idx;
  logic             done_q;
  logic             fire, rnd_step;
  logic [RND_W-1:0] rnd;

  assign fire     = sym_valid_o && sym_ready_i;
  assign rnd_step = fire && (state == ST_OPEN || state == ST_FILL);

  rnd_shift16 #(.W(RND_W)) u_rnd (
    .clk   (clk),
    .rst_n (rst_n),
    .step_i(rnd_step),
    .val_o (rnd)
  );

  pad_len_pick #(.LEN_W(LEN_W), .RND_W(RND_W)) u_pick (
    .rnd_i(rnd),
    .lo_i (lo_q),
    .hi_i (hi_q),
    .len_o(drawn_len)
  );

  always_comb begin
    sym_valid_o = 1'b0;
    sym_k_o     = 1'b0;
    sym_data_o  = 8'h00;
    unique case (state)
      ST_OPEN:  begin sym_valid_o = 1'b1; sym_k_o = 1'b1; sym_data_o = SYM_OPEN;  end
      ST_STAMP: begin sym_valid_o = 1'b1; sym_data_o = stamp_q[TS_W-1 -: 8];      end
      ST_FILL:  begin sym_valid_o = 1'b1; sym_data_o = rnd[7:0];                  end
      ST_CLOSE: begin sym_valid_o = 1'b1; sym_k_o = 1'b1; sym_data_o = SYM_CLOSE; end
      default:  ;
    endcase
  end

  assign busy_o = (state != ST_IDLE);
  assign done_o = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      frames_left <= '0;
      lo_q        <= '0;
      hi_q        <= '0;
      fill_left   <= '0;
      stamp_q     <= '0;
      stamp_idx   <= '0;
      done_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: if (start_i) begin
          lo_q        <= pad_min_i;
          hi_q        <= pad_max_i;
          frames_left <= frame_cnt_i;
          if (frame_cnt_i == '0) done_q <= 1'b1;
          else                   state  <= ST_OPEN;
        end
        ST_OPEN: if (fire) begin
          stamp_q   <= time_i;
          fill_left <= drawn_len;
          stamp_idx <= '0;
          state     <= ST_STAMP;
        end
        ST_STAMP: if (fire) begin
          stamp_q   <= stamp_q << 8;
          stamp_idx <= stamp_idx + TIDX_W'(1);
          if (stamp_idx == TIDX_LAST)
            state <= (fill_left == '0) ? ST_CLOSE : ST_FILL;
        end
        ST_FILL: if (fire) begin
          fill_left <= fill_left - LEN_W'(1);
          if (fill_left == LEN_W'(1)) state <= ST_CLOSE;
        end
        ST_CLOSE: if (fire) begin
          frames_left <= frames_left - CNT_W'(1);
          if (frames_left == CNT_W'(1)) begin
            state  <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            state <= ST_GAP;
          end
        end
        ST_GAP:  state <= ST_OPEN;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: the control flag appears only on the two delimiters
  p_k_only_delims_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid_o && sym_k_o) |-> (sym_data_o == SYM_OPEN || sym_data_o == SYM_CLOSE));

  // R7: a stalled byte stays frozen
  p_hold_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid_o && !sym_ready_i) |=>
      (sym_valid_o && $stable(sym_data_o) && $stable(sym_k_o)));

  // R8: every accepted closing delimiter is followed by an idle slot
  p_gap_after_close_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && sym_k_o && sym_data_o == SYM_CLOSE) |=> !sym_valid_o);

  // R9: done is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R5: the drawn filler count lies in the latched window
  p_len_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && state == ST_OPEN) |=>
      ((hi_q < lo_q) ? (fill_left == lo_q)
                     : (fill_left >= lo_q && fill_left <= hi_q)));

  // R2: a frame opens only after a start has been taken
  p_open_needs_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sym_valid_o) |-> (sym_k_o && sym_data_o == SYM_OPEN && busy_o));
endmodule

// File: tb/sim_pkt_burst_gen.sv
module sim_pkt_burst_gen;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  cnt_in = '0, lo_in = '0, hi_in = '0;
  logic [31:0] tcnt = '0;
  logic [7:0]  data;
  logic        k, valid, busy, done;
  logic        ready = 1'b1;

  pkt_burst_gen u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .frame_cnt_i(cnt_in),
    .pad_min_i(lo_in), .pad_max_i(hi_in), .time_i(tcnt),
    .sym_data_o(data), .sym_k_o(k), .sym_valid_o(valid), .sym_ready_i(ready),
    .busy_o(busy), .done_o(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) tcnt <= tcnt + 32'd7;

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] rnd_next(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  // reference model state
  logic [15:0] m_rnd = 16'hACE1;
  bit    m_busy = 0, m_gap = 0, m_done_next = 0, run = 0;
  int    m_left = 0, m_lo = 0, m_hi = 0, m_frames_seen = 0;
  int    q_data[$];
  bit    q_k[$];
  string q_tag[$];
  bit    prev_stall = 0;
  logic [7:0] prev_data;
  logic  prev_k;

  // stimulus requests
  bit   start_req = 0;
  int   req_cnt, req_lo, req_hi;
  int   ready_mode = 0;

  always @(negedge clk) begin
    if (run) begin
      bit exp_valid;
      bit busy_before;
      exp_valid = m_busy && !m_gap;
      chk(valid == exp_valid, m_gap ? "R8" : "R2", "valid", valid, exp_valid);
      if (exp_valid && valid) begin
        if (q_data.size() == 0) begin
          chk(data == 8'hFB && k == 1'b1, "R3", "open symbol", {k, data}, {1'b1, 8'hFB});
        end else begin
          chk(data == q_data[0][7:0] && k == q_k[0], q_tag[0], "byte",
              {k, data}, {q_k[0], q_data[0][7:0]});
        end
      end
      if (prev_stall)
        chk(valid && data == prev_data && k == prev_k, "R7", "held byte",
            {valid, k, data}, {1'b1, prev_k, prev_data});
      chk(done == m_done_next, "R9", "done", done, m_done_next);
      chk(busy == m_busy, "R9", "busy", busy, m_busy);
      m_gap = 0;
      m_done_next = 0;

      // drive inputs for the coming edge
      ready = (ready_mode == 0) ? 1'b1 : (($urandom % 3) != 0);
      start = 1'b0;
      if (start_req) begin
        start = 1'b1; cnt_in = 8'(req_cnt); lo_in = 8'(req_lo); hi_in = 8'(req_hi);
        start_req = 0;
      end
      prev_stall = valid && !ready;
      prev_data  = data;
      prev_k     = k;

      // model update for the coming edge
      busy_before = m_busy;
      if (valid && ready) begin
        if (q_data.size() == 0) begin
          int len;
          for (int b = 3; b >= 0; b--) begin
            q_data.push_back(int'(tcnt[8*b +: 8])); q_k.push_back(0); q_tag.push_back("R4");
          end
          if (m_hi < m_lo) len = m_lo;
          else len = m_lo + int'(m_rnd % 16'(m_hi - m_lo + 1));
          m_rnd = rnd_next(m_rnd);
          for (int j = 0; j < len; j++) begin
            q_data.push_back(int'(m_rnd[7:0])); q_k.push_back(0); q_tag.push_back("R6");
            m_rnd = rnd_next(m_rnd);
          end
          q_data.push_back(8'hFD); q_k.push_back(1); q_tag.push_back("R3");
        end else begin
          bit was_close;
          was_close = q_k[0] && q_data[0] == 8'hFD;
          void'(q_data.pop_front()); void'(q_k.pop_front()); void'(q_tag.pop_front());
          if (was_close) begin
            m_frames_seen++;
            m_left--;
            if (m_left == 0) begin m_busy = 0; m_done_next = 1; end
            else m_gap = 1;
          end
        end
      end
      if (start && !busy_before) begin
        m_lo = int'(lo_in); m_hi = int'(hi_in); m_left = int'(cnt_in);
        m_frames_seen = 0;
        if (m_left == 0) m_done_next = 1;
        else m_busy = 1;
      end
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic run_burst(input int c, input int lo, input int hi, input int mode,
                           input bit poke_mid);
    @(posedge clk);
    ready_mode = mode;
    req_cnt = c; req_lo = lo; req_hi = hi; start_req = 1;
    @(posedge clk); @(posedge clk);
    if (poke_mid) begin
      // R2: a strobe during a burst must be ignored
      repeat (5) @(posedge clk);
      req_cnt = 9; req_lo = 1; req_hi = 1; start_req = 1;
    end
    while (m_busy || start_req) @(posedge clk);
    repeat (3) @(posedge clk);
    chk(m_frames_seen == c, "R2", "frames in burst", m_frames_seen, c);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(!valid && !done && !busy, "R1", "reset outputs", {valid, done, busy}, 0);
    @(posedge clk);
    run = 1;
    run_burst(3, 2, 5, 0, 0);     // R3 R4 R6 basic burst
    run_burst(4, 0, 3, 1, 0);     // R7 back-pressure, zero-length filler allowed
    run_burst(2, 6, 2, 1, 0);     // R5 inverted window clamps to min
    run_burst(3, 4, 4, 0, 0);     // R5 fixed length
    run_burst(0, 1, 3, 0, 0);     // R9 zero count gives only done
    run_burst(3, 1, 6, 1, 1);     // R2 mid-burst strobe ignored
    run_burst(2, 0, 255, 1, 0);   // R5 widest window
    chk(!valid && !busy, "R9", "idle after bursts", {valid, busy}, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule